// File: doc/BRIEF.md
# Audio codec reset sequencer

This controller converts a software run/reset control bit into the timed reset, zero-detect flag and output-gating signals of a multi-channel audio converter's digital datapath. Every delay is measured in frame-clock periods. The frame clock (the left/right sample clock) is brought into the system-clock domain, and each of its rising edges becomes a one-cycle frame strobe that advances the delay counters.

Clearing the control bit raises the zero-detect flag at once. The datapath reset follows a few frames later. Setting the bit again releases the datapath reset after a short delay and the zero-detect flag after a longer one. The release also opens a 516-frame ADC initialization window, and the serial ADC outputs stay forced to zero until that window closes. An active-low hard power-down pin overrides the whole sequence. Register contents outside the datapath are not touched by this block.

Top module: `audio_rst_seq`

## Requirements
- R1: After the synchronized control bit falls, `dp_rst_o` rises on the fifth frame strobe that follows, which is 4 to 5 frame periods later. It does not rise before that strobe.
- R2: After the synchronized control bit rises, `dp_rst_o` falls on the second frame strobe that follows, which is 1 to 2 frame periods later.
- R3: `zero_flag_o` rises within 4 system clocks of the control bit falling, with no frame strobe needed.
- R4: After the control bit rises, `zero_flag_o` falls on the seventh frame strobe that follows, which is 6 to 7 frame periods later. Because of this it never falls while `dp_rst_o` is high.
- R5: `adc_init_o` goes high in the same cycle that `dp_rst_o` releases. It stays high for 516 frame strobes. A falling control bit or a hard power-down clears it early. It is never high together with `dp_rst_o`.
- R6: `sdata_zero_o` is high whenever `pdn_ni` is low, `dp_rst_o` is high or `adc_init_o` is high. Otherwise it is low.
- R7: While `pdn_ni` is low, the next clock edge sets `dp_rst_o` and `zero_flag_o` high and `adc_init_o` low, and all pending counts are discarded. When `pdn_ni` rises with the control bit at 1, the block behaves as if the bit had just risen.
- R8: A frame strobe is the rising edge of `frame_i`. If the frame clock stops, the pending count and all outputs hold. Counting resumes when edges return.
- R9: A change of the control bit while a delay is pending cancels that delay. The opposite delay restarts from zero.
- R10: `init_done_o` is a one-clock pulse in the cycle where `adc_init_o` falls at the end of a complete 516-frame window.
- R11: While `rst_ni` is low and directly after it, `dp_rst_o` and `zero_flag_o` are high, and `adc_init_o` and `init_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame clock, asynchronous |
| pdn_ni | input | 1 | Hard power-down, active low, synchronous to clk_i |
| run_bit_i | input | 1 | Software control bit, 1 = run, 0 = reset, asynchronous |
| dp_rst_o | output | 1 | Datapath reset, active high |
| zero_flag_o | output | 1 | Zero-detect flag |
| adc_init_o | output | 1 | ADC initialization window active |
| sdata_zero_o | output | 1 | Forces the serial data outputs low |
| init_done_o | output | 1 | One-clock pulse when the init window completes |

## Verification
The assertions assume that `pdn_ni` is already synchronous to the system clock, since it acts on the next edge without a synchronizer. They also assume that a frame period spans many system clocks, so that synchronizer latency never merges or drops strobes. The bench drives `pdn_ni` on the falling clock edge and runs a frame period of 16 clocks. It changes the control bit only at falling frame edges, well away from the rising edges that are counted. Under these conditions each delay can be checked as an exact strobe count instead of a range.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RST_ON_FRAMES  = 5;
  localparam int unsigned RST_OFF_FRAMES = 2;
  localparam int unsigned FLAG_OFF_FRAMES = 7;
  localparam int unsigned INIT_FRAMES    = 516;
  localparam int unsigned SYNC_STAGES    = 2;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rs_frame_timer.sv
module rs_frame_timer #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic stop_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          last_tick;

  assign last_tick = busy_q && tick_i && (cnt_q == LAST);
  // stop wins over start; a fresh start drops any pending completion
  assign done_o = last_tick && !stop_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (last_tick) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_rst_seq.sv
module audio_rst_seq
  import rs_pkg::*;
#(
  parameter int unsigned RST_ON  = RST_ON_FRAMES,
  parameter int unsigned RST_OFF = RST_OFF_FRAMES,
  parameter int unsigned FLAG_OFF = FLAG_OFF_FRAMES,
  parameter int unsigned INIT_LEN = INIT_FRAMES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic pdn_ni,
  input  logic run_bit_i,
  output logic dp_rst_o,
  output logic zero_flag_o,
  output logic adc_init_o,
  output logic sdata_zero_o,
  output logic init_done_o
);
  logic [1:0] sync_q;
  logic       frame_s, run_s, frame_q, run_q;
  logic       tick, run_eff, fall, rise, pd;
  logic       on_done, off_done, flag_done, init_end;
  logic       dp_rst_q, flag_q, init_q, done_q;

  rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({frame_i, run_bit_i}),
    .q_o   (sync_q)
  );
  assign frame_s = sync_q[1];
  assign run_s   = sync_q[0];

  assign pd      = !pdn_ni;
  assign run_eff = run_s && pdn_ni;
  assign tick    = frame_s && !frame_q;
  assign fall    = run_q && !run_eff;
  assign rise    = !run_q && run_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      frame_q <= frame_s;
      run_q   <= run_eff;
    end
  end

  rs_frame_timer #(.LIMIT(RST_ON)) u_on_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(fall), .stop_i(rise || pd), .done_o(on_done)
  );

  rs_frame_timer #(.LIMIT(RST_OFF)) u_off_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(rise), .stop_i(fall || pd), .done_o(off_done)
  );

  rs_frame_timer #(.LIMIT(FLAG_OFF)) u_flag_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(rise), .stop_i(fall || pd), .done_o(flag_done)
  );

  rs_frame_timer #(.LIMIT(INIT_LEN)) u_init_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(off_done && dp_rst_q), .stop_i(fall || pd), .done_o(init_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_rst_q <= 1'b1;
      flag_q   <= 1'b1;
      init_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (pd) begin
      dp_rst_q <= 1'b1;
      flag_q   <= 1'b1;
      init_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fall) begin
        flag_q <= 1'b1;
        init_q <= 1'b0;
      end
      if (on_done) dp_rst_q <= 1'b1;
      if (off_done && dp_rst_q) begin
        dp_rst_q <= 1'b0;
        init_q   <= 1'b1;
      end
      if (flag_done) flag_q <= 1'b0;
      if (init_end) begin
        init_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign dp_rst_o     = dp_rst_q;
  assign zero_flag_o  = flag_q;
  assign adc_init_o   = init_q;
  assign init_done_o  = done_q;
  assign sdata_zero_o = pd || dp_rst_q || init_q;
endmodule

// File: rtl/audio_rst_seq_chk.sv
module audio_rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pdn_ni,
  input logic dp_rst_o,
  input logic zero_flag_o,
  input logic adc_init_o,
  input logic sdata_zero_o,
  input logic init_done_o
);
  assert_pdn_forces_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |=> dp_rst_o && zero_flag_o && !adc_init_o);

  assert_rst_gates_sdata_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rst_o |-> sdata_zero_o);

  assert_init_gates_sdata_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_init_o |-> sdata_zero_o);

  assert_init_excl_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_init_o |-> !dp_rst_o);

  assert_rst_after_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_rst_o) |-> zero_flag_o);

  assert_flag_after_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zero_flag_o) |-> !dp_rst_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !init_done_o);

  assert_done_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $fell(adc_init_o));
endmodule

bind audio_rst_seq audio_rst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pdn_ni      (pdn_ni),
  .dp_rst_o    (dp_rst_o),
  .zero_flag_o (zero_flag_o),
  .adc_init_o  (adc_init_o),
  .sdata_zero_o(sdata_zero_o),
  .init_done_o (init_done_o)
);

// File: tb/audio_rst_seq_tb.sv
module audio_rst_seq_tb;
  localparam int ON_N = 5, OFF_N = 2, FLAG_N = 7, INIT_N = 516;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0, frame = 1'b0, pdn_ni = 1'b1, run_bit = 1'b0;
  logic dp_rst, zflag, ainit, sdz, idone;
  logic frame_run = 1'b1;
  int   rises = 0, n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  audio_rst_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame), .pdn_ni(pdn_ni),
    .run_bit_i(run_bit), .dp_rst_o(dp_rst), .zero_flag_o(zflag),
    .adc_init_o(ainit), .sdata_zero_o(sdz), .init_done_o(idone)
  );

  // frame clock: period 16 clocks, edges on falling clk
  always begin
    @(negedge clk);
    if (frame_run) begin
      frame = 1'b1;
      rises++;
      repeat (HALF) @(negedge clk);
      frame = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return dp_rst;
      1: return zflag;
      default: return ainit;
    endcase
  endfunction

  // wait until output sel reaches val; report frame edges since r0
  task automatic wait_out(input int sel, input logic val, input int r0,
                          input int max_cyc, output int nr, output bit ok);
    int n = 0;
    while (sig(sel) !== val && n < max_cyc) begin
      @(negedge clk);
      n++;
    end
    ok = (sig(sel) === val);
    nr = rises - r0;
  endtask

  task automatic set_bit_at_fall(input logic v, output int r0);
    @(negedge frame);
    run_bit = v;
    r0 = rises;
  endtask

  // full release from the bit rising (or pdn release); checks R2, R4, R5, R6, R10
  task automatic release_seq(input int r0, input string tag);
    int nr, r1; bit ok;
    wait_out(0, 1'b0, r0, 4000, nr, ok);
    chk(ok && nr == OFF_N, {"R2 release ", tag}, nr, OFF_N);
    r1 = rises;
    chk(ainit === 1'b1, {"R5 init opens ", tag}, ainit, 1);
    chk(sdz === 1'b1, {"R6 gated in init ", tag}, sdz, 1);
    wait_out(1, 1'b0, r0, 4000, nr, ok);
    chk(ok && nr == FLAG_N, {"R4 flag release ", tag}, nr, FLAG_N);
    wait_out(2, 1'b0, r1, 20000, nr, ok);
    chk(ok && nr == INIT_N, {"R5 init length ", tag}, nr, INIT_N);
    chk(idone === 1'b1, {"R10 done pulse ", tag}, idone, 1);
    @(negedge clk);
    chk(idone === 1'b0, {"R10 done width ", tag}, idone, 0);
    chk(sdz === 1'b0, {"R6 ungated ", tag}, sdz, 0);
  endtask

  initial begin
    int r0, nr, k; bit ok;
    repeat (3) @(negedge clk);
    chk(dp_rst === 1'b1 && zflag === 1'b1, "R11 in reset", {dp_rst, zflag}, 3);
    chk(ainit === 1'b0 && idone === 1'b0, "R11 in reset", {ainit, idone}, 0);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk);
    chk(dp_rst === 1'b1 && zflag === 1'b1 && sdz === 1'b1, "R11 after reset",
        {dp_rst, zflag, sdz}, 7);

    // normal exit
    set_bit_at_fall(1'b1, r0);
    release_seq(r0, "first");

    // entry: flag immediate, reset on fifth strobe
    set_bit_at_fall(1'b0, r0);
    k = 0;
    while (zflag !== 1'b1 && k < 6) begin @(negedge clk); k++; end
    chk(zflag === 1'b1 && k <= 4, "R3 flag latency", k, 4);
    chk(dp_rst === 1'b0, "R1 not early", dp_rst, 0);
    wait_out(0, 1'b1, r0, 4000, nr, ok);
    chk(ok && nr == ON_N, "R1 assert delay", nr, ON_N);
    chk(sdz === 1'b1, "R6 gated in reset", sdz, 1);

    // restart: fall during init, back to 1 mid-count, then 0 again
    set_bit_at_fall(1'b1, r0);
    wait_out(0, 1'b0, r0, 4000, nr, ok);
    set_bit_at_fall(1'b0, r0);
    repeat (10) @(negedge clk);
    chk(ainit === 1'b0, "R5 init cut by bit", ainit, 0);
    repeat (3) @(posedge frame);
    set_bit_at_fall(1'b1, r0);
    @(posedge frame);
    set_bit_at_fall(1'b0, r0);
    chk(dp_rst === 1'b0 && zflag === 1'b1, "R9 cancelled assert", {dp_rst, zflag}, 1);
    wait_out(0, 1'b1, r0, 4000, nr, ok);
    chk(ok && nr == ON_N, "R9 restarted count", nr, ON_N);

    // frame clock stopped during pending assert
    set_bit_at_fall(1'b1, r0);
    wait_out(0, 1'b0, r0, 4000, nr, ok);
    @(negedge frame);
    frame_run = 1'b0;
    repeat (HALF + 2) @(negedge clk);
    run_bit = 1'b0;
    r0 = rises;
    repeat (300) @(negedge clk);
    chk(dp_rst === 1'b0 && zflag === 1'b1, "R8 hold while stopped", {dp_rst, zflag}, 1);
    chk(rises == r0, "R8 no edges", rises - r0, 0);
    frame_run = 1'b1;
    wait_out(0, 1'b1, r0, 4000, nr, ok);
    chk(ok && nr == ON_N, "R8 resume count", nr, ON_N);

    // hard power-down during init window
    set_bit_at_fall(1'b1, r0);
    wait_out(1, 1'b0, r0, 4000, nr, ok);
    chk(ainit === 1'b1, "R5 window open", ainit, 1);
    @(negedge clk);
    pdn_ni = 1'b0;
    @(negedge clk);
    chk(dp_rst === 1'b1 && zflag === 1'b1 && ainit === 1'b0, "R7 override",
        {dp_rst, zflag, ainit}, 6);
    chk(sdz === 1'b1, "R6 pdn gating", sdz, 1);
    repeat (4) @(posedge frame);
    @(negedge clk);
    chk(dp_rst === 1'b1 && zflag === 1'b1, "R7 held", {dp_rst, zflag}, 3);
    @(negedge frame);
    pdn_ni = 1'b1;
    r0 = rises;
    release_seq(r0, "after pdn");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule